// File: doc/BRIEF.md
# Threshold-Started Transmit Byte Queue

This block is a byte-wide transmit queue that sits between a DMA engine that fills it and a frame transmitter that drains it. Each stored byte carries a flag that marks the end of a frame. The block also decides when the transmitter may begin sending a frame. Until it makes that decision, the transmitter sees no valid data.

A software-visible start-level register holds an 11-bit field. The field is multiplied by four to give a byte count. A start request is raised on the first of three events: the queue holds more bytes than that count, the queue is full, or a whole frame (its end byte included) is present. The request stays up until the transmitter takes the end-of-frame byte. After that the decision is made again for whatever the queue then holds. The register can be written only while the transmitter reports that it is idle.

Top module: `txq_start_fifo`

## Requirements
- R1: After reset, start_req is 0, wr_ready is 1, rd_valid is 0 and cfg_rdata reads 0.
- R2: cfg_rdata[10:0] returns the last accepted write of cfg_wdata[10:0]. Bits 31..11 always read 0, whatever value was written to them.
- R3: A register write presented while xmit_busy is 1 is dropped, and the stored start level keeps its value.
- R4: When the number of stored bytes is strictly greater than 4 × cfg_rdata[10:0], start_req is 1 on the next cycle. A start level above the queue depth never triggers on its own.
- R5: When the queue is full (DEPTH bytes stored), start_req is 1 on the next cycle, whatever the start level.
- R6: When at least one stored byte carries wr_last=1, start_req is 1 on the next cycle, even if the frame is shorter than the start level.
- R7: With a start level of 0, a single stored byte is enough to raise start_req on the next cycle.
- R8: Once start_req is 1, it stays 1 until a byte with rd_last=1 is taken (rd_valid and rd_ready both 1). On the next cycle it is 0, and the conditions of R4 to R6 are then evaluated again.
- R9: wr_ready is 0 exactly when DEPTH bytes are stored, and a byte is stored only when wr_valid and wr_ready are both 1. Bytes leave in write order with their end flags, and none is lost or repeated.
- R10: rd_valid is 1 only while start_req is 1 and at least one byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Start-level register write strobe |
| cfg_wdata | input | 32 | Register write data; only bits 10..0 are kept |
| cfg_rdata | output | 32 | Register read value |
| xmit_busy | input | 1 | Transmitter active; register writes are ignored while this is 1 |
| wr_valid | input | 1 | Writer offers a byte |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Offered byte ends a frame |
| wr_ready | output | 1 | Queue can accept a byte |
| rd_valid | output | 1 | Byte available to the transmitter |
| rd_data | output | 8 | Oldest stored byte |
| rd_last | output | 1 | Oldest stored byte ends a frame |
| rd_ready | input | 1 | Transmitter takes the byte |
| start_req | output | 1 | Transmitter may begin sending |

## Verification
The set and clear of the start request can land on the same clock edge. This happens when the transmitter takes the end-of-frame byte of one frame while a second complete frame, or enough bytes, is already queued. The bench provokes this by queuing two short frames before draining. It then expects start_req to fall for exactly one cycle and rise again. Two start conditions are also made to coincide: a single end-marked byte written under a start level of zero. A write is also offered against a full queue so that it must be refused. A behavioural queue model predicts every output on every cycle and is compared against the design.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int REG_W  = 32;
    localparam int THR_W  = 11;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } txq_beat_t;

    // start level field scaled to a byte count
    function automatic logic [THR_W+1:0] level_to_bytes(input logic [THR_W-1:0] fld);
        return {fld, 2'b00};
    endfunction

endpackage

// File: rtl/txq_thr_reg.sv
module txq_thr_reg
    import txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [THR_W-1:0] wfield,
    input  logic             busy,
    output logic [THR_W-1:0] thr,
    output logic [REG_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= '0;
        end else if (we && !busy) begin
            thr <= wfield;
        end
    end

    assign rdata = {{(REG_W-THR_W){1'b0}}, thr};

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> $stable(thr));

endmodule

// File: rtl/txq_ring.sv
module txq_ring
    import txq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  txq_beat_t        push_beat,
    input  logic             pop,
    output txq_beat_t        head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    txq_beat_t        mem [DEPTH];
    logic [AW:0]      wptr;
    logic [AW:0]      rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr[AW-1:0]] <= push_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign empty = (wptr == rptr);
    assign level = wptr - rptr;
    assign head  = mem[rptr[AW-1:0]];

    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_level_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level >= $past(level)) ? (level - $past(level)) : ($past(level) - level)) <= 1);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> level == LVL_W'(DEPTH));

endmodule

// File: rtl/txq_start_ctl.sv
module txq_start_ctl
    import txq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int LVL_W = $clog2(DEPTH) + 1,
    localparam int CMP_W = (LVL_W > THR_W + 2) ? LVL_W : THR_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             full,
    input  logic [THR_W-1:0] thr,
    input  logic             eof_in,
    input  logic             eof_out,
    output logic             start
);

    logic [LVL_W-1:0] frames;
    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] thr_x;
    logic             over_level;
    logic             frame_ready;
    logic             go;

    always_ff @(posedge clk) begin
        if (rst) begin
            frames <= '0;
        end else begin
            case ({eof_in, eof_out})
                2'b10:   frames <= frames + 1'b1;
                2'b01:   frames <= frames - 1'b1;
                default: frames <= frames;
            endcase
        end
    end

    assign lvl_x       = CMP_W'(level);
    assign thr_x       = CMP_W'(level_to_bytes(thr));
    assign over_level  = lvl_x > thr_x;
    assign frame_ready = frames != '0;
    assign go          = over_level || full || frame_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            start <= 1'b0;
        end else if (eof_out) begin
            start <= 1'b0;
        end else if (go) begin
            start <= 1'b1;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !eof_out) |=> start);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        eof_out |=> !start);

    p_full_start_r5: assert property (@(posedge clk) disable iff (rst)
        (full && !start) |=> start);

    p_frame_start_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_ready && !start) |=> start);

    p_level_start_r4: assert property (@(posedge clk) disable iff (rst)
        (over_level && !start) |=> start);

endmodule

// File: rtl/txq_start_fifo.sv
module txq_start_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              xmit_busy,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_last,
    input  logic              rd_ready,
    output logic              start_req
);

    logic [THR_W-1:0] thr;
    logic             full;
    logic             empty;
    logic [LVL_W-1:0] level;
    logic             push;
    logic             pop;
    txq_beat_t        in_beat;
    txq_beat_t        head;

    txq_thr_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wfield (cfg_wdata[THR_W-1:0]),
        .busy   (xmit_busy),
        .thr    (thr),
        .rdata  (cfg_rdata)
    );

    assign in_beat = '{data: wr_data, last: wr_last};
    assign push    = wr_valid && !full;
    assign pop     = rd_valid && rd_ready;

    txq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_beat (in_beat),
        .pop       (pop),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .level     (level)
    );

    txq_start_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .full    (full),
        .thr     (thr),
        .eof_in  (push && wr_last),
        .eof_out (pop && head.last),
        .start   (start_req)
    );

    assign wr_ready = !full;
    assign rd_valid = start_req && !empty;
    assign rd_data  = head.data;
    assign rd_last  = head.last;

    p_gate_read_r10: assert property (@(posedge clk) disable iff (rst)
        (!start_req) |-> !rd_valid);

endmodule

// File: tb/tb_txq_start_fifo.sv
module tb_txq_start_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int MAXCYC     = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xmit_busy = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_last = 1'b0;
    logic        wr_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_last;
    logic        rd_ready = 1'b0;
    logic        start_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit armed = 0;
    bit done = 0;

    // behavioural model
    logic [7:0] q_data[$];
    bit         q_last[$];
    int         m_frames = 0;
    bit         m_start = 0;
    int         m_thr = 0;
    int         sz;
    bit         wfire, rfire, cond, clr;
    logic [7:0] seq = 8'h00;

    txq_start_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xmit_busy(xmit_busy), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_ready(rd_ready), .start_req(start_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            q_data.delete();
            q_last.delete();
            m_frames = 0;
            m_start = 0;
            m_thr = 0;
        end else begin
            sz    = q_data.size();
            wfire = wr_valid && (sz < DEPTH);
            rfire = rd_ready && m_start && (sz > 0);
            cond  = (sz > 4 * m_thr) || (sz == DEPTH) || (m_frames > 0);
            clr   = rfire && q_last[0];
            if (cfg_we && !xmit_busy) m_thr = int'(cfg_wdata[10:0]);
            m_start = clr ? 1'b0 : (m_start || cond);
            if (rfire) begin
                if (q_last[0]) m_frames--;
                void'(q_data.pop_front());
                void'(q_last.pop_front());
            end
            if (wfire) begin
                q_data.push_back(wr_data);
                q_last.push_back(wr_last);
                if (wr_last) m_frames++;
            end
        end
        if (cyc >= MAXCYC && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !rst) begin
            chk(start_req === m_start, "R4 R5 R6 R8", "start_req", start_req, m_start);
            chk(wr_ready === (q_data.size() < DEPTH), "R9", "wr_ready", wr_ready, q_data.size() < DEPTH);
            chk(rd_valid === (m_start && q_data.size() > 0), "R10", "rd_valid", rd_valid, m_start && q_data.size() > 0);
            chk(cfg_rdata === {21'b0, m_thr[10:0]}, "R2", "cfg_rdata", cfg_rdata, {21'b0, m_thr[10:0]});
            if (q_data.size() > 0 && m_start) begin
                chk(rd_data === q_data[0], "R9", "rd_data", rd_data, q_data[0]);
                chk(rd_last === q_last[0], "R9", "rd_last", rd_last, q_last[0]);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_byte(input bit last);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data = seq;
        wr_last = last;
        seq = seq + 8'h01;
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic wr_stop();
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic wr_burst(input int n, input bit last_at_end);
        for (int i = 0; i < n; i++) wr_byte(last_at_end && (i == n - 1));
        wr_stop();
    endtask

    task automatic drain(input int n);
        @(negedge clk);
        rd_ready = 1'b1;
        repeat (n) @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        idle(1);
        // R1 reset state
        chk(start_req == 1'b0, "R1", "start_req after reset", start_req, 0);
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        chk(cfg_rdata == 32'h0, "R1", "cfg_rdata after reset", cfg_rdata, 0);

        // R2 register field and reserved bits
        cfg_wr(32'hFFFF_FFFF);
        idle(1);
        chk(cfg_rdata == 32'h0000_07FF, "R2", "all-ones write", cfg_rdata, 32'h7FF);
        cfg_wr(32'hFFFF_F800);
        idle(1);
        chk(cfg_rdata == 32'h0, "R2", "reserved-only write", cfg_rdata, 0);

        // R3 write dropped while busy
        cfg_wr(32'h0000_0123);
        xmit_busy = 1'b1;
        cfg_wr(32'h0000_0055);
        xmit_busy = 1'b0;
        idle(1);
        chk(cfg_rdata == 32'h123, "R3", "write while busy", cfg_rdata, 32'h123);

        // R4 threshold of 8 bytes, strict greater-than
        cfg_wr(32'd2);
        wr_burst(8, 1'b0);
        idle(3);
        chk(start_req == 1'b0, "R4", "8 bytes at level 8", start_req, 0);
        chk(rd_valid == 1'b0, "R10", "no data before start", rd_valid, 0);
        wr_burst(1, 1'b0);
        idle(3);
        chk(start_req == 1'b1, "R4", "9 bytes at level 8", start_req, 1);
        // R8 sticky while emptied without end byte
        drain(12);
        idle(2);
        chk(start_req == 1'b1, "R8", "held after drain w/o end", start_req, 1);
        chk(rd_valid == 1'b0, "R10", "empty gives no valid", rd_valid, 0);
        wr_burst(1, 1'b1);
        drain(3);
        idle(2);
        chk(start_req == 1'b0, "R8", "cleared after end byte", start_req, 0);

        // R6 short frame below threshold
        cfg_wr(32'd100);
        wr_burst(3, 1'b1);
        idle(3);
        chk(start_req == 1'b1, "R6", "short frame start", start_req, 1);
        drain(5);
        idle(2);
        chk(start_req == 1'b0, "R6", "short frame done", start_req, 0);

        // R7 zero level
        cfg_wr(32'd0);
        wr_burst(1, 1'b0);
        idle(3);
        chk(start_req == 1'b1, "R7", "one byte at level 0", start_req, 1);
        wr_burst(1, 1'b1);
        drain(4);
        idle(2);
        chk(start_req == 1'b0, "R7", "cleared", start_req, 0);

        // overlap: level 0 and end byte in one write
        wr_burst(1, 1'b1);
        idle(3);
        chk(start_req == 1'b1, "R6", "overlap level+frame", start_req, 1);
        drain(3);
        idle(2);
        chk(start_req == 1'b0, "R8", "overlap cleared", start_req, 0);

        // R5 full with level beyond depth
        cfg_wr(32'h7FF);
        wr_burst(DEPTH - 1, 1'b0);
        idle(3);
        chk(start_req == 1'b0, "R4", "huge level not reached", start_req, 0);
        wr_burst(1, 1'b0);
        idle(3);
        chk(start_req == 1'b1, "R5", "full start", start_req, 1);
        chk(wr_ready == 1'b0, "R9", "full blocks writer", wr_ready, 0);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data = 8'hAA;
        idle(3);
        wr_valid = 1'b0;
        idle(1);
        drain(DEPTH + 4);
        idle(2);
        chk(start_req == 1'b1, "R8", "held after full drain", start_req, 1);
        wr_burst(1, 1'b1);
        drain(3);
        idle(2);
        chk(start_req == 1'b0, "R8", "cleared after full", start_req, 0);

        // R8 re-decision with two queued frames
        cfg_wr(32'd100);
        wr_burst(2, 1'b1);
        wr_burst(2, 1'b1);
        idle(3);
        chk(start_req == 1'b1, "R6", "two frames queued", start_req, 1);
        drain(12);
        idle(2);
        chk(start_req == 1'b0, "R8", "both frames sent", start_req, 0);
        chk(rd_valid == 1'b0 && wr_ready == 1'b1, "R9", "queue empty", rd_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule